// File: doc/BRIEF.md
# Periodic Monitor Mode Sequencer

This block runs a low-duty-cycle surveillance mode for an image sensor. While the monitor enable is low, the sensor runs normally. When it goes high, the sequencer starts a burst in which a programmed number of frames is captured. It then puts the sensor to sleep for a long fixed period. When that period has been timed out, the next burst begins. The cycle repeats until the enable is cleared, and the block then returns to normal operation.

The sleep period is a count of master-clock cycles set by a parameter. Its default corresponds to five minutes of a master clock of roughly 26.66 MHz, and a bench can shorten it. The timer runs on the master clock, so that clock must keep running during sleep.

Frames are counted in pairs of strobes. A frame-start strobe is accepted only while the capture permit is high. The matching frame-end strobe completes the frame. A frame that was already in progress when the burst began is allowed to finish, but it is not counted. A frame that was started legally always completes before the sensor sleeps.

There are three states. NORMAL is normal operation. CAPTURE is the burst. SLEEP is the timed sleep. The transitions are:
- NORMAL to CAPTURE when the enable is high.
- CAPTURE to SLEEP on the frame end of the last counted frame.
- SLEEP to CAPTURE when the timer expires.
- Any state to NORMAL when the enable is low.

Top module: `monitor_cycle_seq`

## Requirements
- R1: After reset the block is in NORMAL: `awake`=1, `capture_ok`=1, `monitor_on`=0.
- R2: In NORMAL, sampling `mode_en`=1 at a clock edge moves the block to CAPTURE after that edge: `monitor_on`=1, `awake`=1, and `capture_ok`=1.
- R3: In CAPTURE, a frame-start accepted while `capture_ok`=1 counts as a started frame. After the edge that accepts the N-th started frame, `capture_ok` is 0. N is the burst length.
- R4: The frame-end that completes the N-th started frame moves the block to SLEEP after that edge: `awake`=0, `capture_ok`=0, `monitor_on`=1.
- R5: The block stays in SLEEP for exactly SLEEP_CYCLES clock cycles. It then enters CAPTURE with a fresh frame count.
- R6: In CAPTURE, a frame-end with no accepted frame-start before it is ignored. This covers a frame that was already in progress when the burst began.
- R7: A burst length of 0 is treated as a burst length of 1.
- R8: Sampling `mode_en`=0 at any clock edge puts the block in NORMAL after that edge, from any state.
- R9: A frame-start that arrives while `capture_ok`=0 is ignored and does not complete the burst.
- R10: Frame strobes that arrive during SLEEP neither shorten nor extend the sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, also times the sleep period |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Monitor mode enable |
| burst_len | input | FCW | Frames captured per burst (0 means 1) |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| frame_end | input | 1 | One-cycle strobe at the end of a frame |
| awake | output | 1 | 1 = sensor active, 0 = sleep |
| capture_ok | output | 1 | 1 = a new frame may begin |
| monitor_on | output | 1 | 1 = monitor mode cycle is running |

## Verification
The checker enforces several properties on every cycle:
- A low enable is followed by a return to normal.
- Capture is never permitted while asleep.
- Sleep is entered only on a frame-end edge.
- Monitor mode starts only under the enable.
- No sleep runs longer than the parameter, and a sleep that ends by expiry lasted exactly the parameter.

Only the bench scenarios can show the rest:
- The frame count itself, where a stray frame-end and an extra frame-start leave the burst length unchanged.
- The zero-length burst that behaves as length 1.
- The fresh count after each wake-up.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SLEEP   = 2'd2
    } mcs_state_e;
endpackage

// File: rtl/mcs_frame_tally.sv
module mcs_frame_tally #(
    parameter int FCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [FCW-1:0] burst_len,
    input  logic           frame_start,
    input  logic           frame_end,
    output logic           permit,
    output logic           done
);
    logic [FCW-1:0] target;
    logic [FCW-1:0] started_q;
    logic [FCW-1:0] ended_q;
    logic           in_frame_q;

    // a zero burst length is raised to one frame (R7)
    assign target = (burst_len == '0) ? FCW'(1) : burst_len;
    assign permit = (started_q < target);
    assign done   = frame_end && in_frame_q && (ended_q == target - FCW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q  <= '0;
            ended_q    <= '0;
            in_frame_q <= 1'b0;
        end else if (clr) begin
            started_q  <= '0;
            ended_q    <= '0;
            in_frame_q <= 1'b0;
        end else begin
            if (frame_start && permit && !in_frame_q) begin
                started_q  <= started_q + FCW'(1);
                in_frame_q <= 1'b1;
            end else if (frame_end && in_frame_q) begin
                ended_q    <= ended_q + FCW'(1);
                in_frame_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mcs_sleep_timer.sv
module mcs_sleep_timer #(
    parameter longint unsigned SLEEP_CYCLES = 64'd7998000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (SLEEP_CYCLES > 2) ? $clog2(SLEEP_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(SLEEP_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    assign expire = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/monitor_cycle_seq.sv
module monitor_cycle_seq
    import mcs_pkg::*;
#(
    parameter int              FCW          = 4,
    parameter longint unsigned SLEEP_CYCLES = 64'd7998000000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_en,
    input  logic [FCW-1:0] burst_len,
    input  logic           frame_start,
    input  logic           frame_end,
    output logic           awake,
    output logic           capture_ok,
    output logic           monitor_on
);
    mcs_state_e state_q, state_d;
    logic       permit, burst_done, sleep_over;

    mcs_frame_tally #(.FCW(FCW)) tally_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state_q != ST_CAPTURE),
        .burst_len  (burst_len),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .permit     (permit),
        .done       (burst_done)
    );

    mcs_sleep_timer #(.SLEEP_CYCLES(SLEEP_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SLEEP),
        .expire(sleep_over)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!mode_en) begin
            state_d = ST_NORMAL;                     // R8
        end else begin
            unique case (state_q)
                ST_NORMAL:  state_d = ST_CAPTURE;    // R2
                ST_CAPTURE: if (burst_done) state_d = ST_SLEEP;  // R4
                ST_SLEEP:   if (sleep_over) state_d = ST_CAPTURE; // R5
                default:    state_d = ST_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        awake      = 1'b1;
        capture_ok = 1'b1;
        monitor_on = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                awake      = 1'b1;
                capture_ok = 1'b1;
                monitor_on = 1'b0;
            end
            ST_CAPTURE: begin
                awake      = 1'b1;
                capture_ok = permit;                 // R3
                monitor_on = 1'b1;
            end
            ST_SLEEP: begin
                awake      = 1'b0;
                capture_ok = 1'b0;
                monitor_on = 1'b1;
            end
            default: begin
                awake      = 1'b1;
                capture_ok = 1'b1;
                monitor_on = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
    parameter longint unsigned SLEEP_CYCLES = 64'd7998000000
) (
    input logic clk,
    input logic rst_n,
    input logic mode_en,
    input logic frame_end,
    input logic awake,
    input logic capture_ok,
    input logic monitor_on
);
    logic [63:0] slp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      slp_cnt <= '0;
        else if (!awake) slp_cnt <= slp_cnt + 64'd1;
        else             slp_cnt <= '0;
    end

    assert_clear_to_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (!monitor_on && awake && capture_ok));

    assert_sleep_no_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> !capture_ok);

    assert_sleep_on_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake) |-> ($past(frame_end) && $past(mode_en)));

    assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(monitor_on) |-> $past(mode_en));

    assert_sleep_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> (slp_cnt < SLEEP_CYCLES));

    assert_sleep_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(awake) && $past(mode_en)) |-> (slp_cnt == SLEEP_CYCLES));
endmodule

bind monitor_cycle_seq mcs_checker #(.SLEEP_CYCLES(SLEEP_CYCLES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .frame_end (frame_end),
    .awake     (awake),
    .capture_ok(capture_ok),
    .monitor_on(monitor_on)
);

// File: tb/monitor_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module monitor_cycle_seq_tb_top;
    localparam int              FCW = 4;
    localparam longint unsigned SLP = 64'd20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_en = 1'b0;
    logic [FCW-1:0] burst_len = '0;
    logic           frame_start = 1'b0;
    logic           frame_end = 1'b0;
    logic           awake, capture_ok, monitor_on;

    typedef struct {
        logic  aw;
        logic  cap;
        logic  mon;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    monitor_cycle_seq #(.FCW(FCW), .SLEEP_CYCLES(SLP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .burst_len(burst_len),
        .frame_start(frame_start), .frame_end(frame_end),
        .awake(awake), .capture_ok(capture_ok), .monitor_on(monitor_on)
    );

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if ({awake, capture_ok, monitor_on} !== {e.aw, e.cap, e.mon}) begin
                bad++;
                $display("FAIL %s: aw/cap/mon actual=%b%b%b expected=%b%b%b",
                         e.tag, awake, capture_ok, monitor_on, e.aw, e.cap, e.mon);
            end
        end
    end

    // driver: apply inputs for one edge and queue the expected post-edge outputs
    task automatic step(input logic en, input logic fs, input logic fe,
                        input logic aw, input logic cap, input logic mon,
                        input string tag);
        exp_t e;
        mode_en     = en;
        frame_start = fs;
        frame_end   = fe;
        @(posedge clk);
        e.aw = aw; e.cap = cap; e.mon = mon; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        frame_start = 1'b0;
        frame_end   = 1'b0;
    endtask

    // burst of n frames, target n, ending in sleep
    task automatic burst(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 1, 0, 1, (i == n - 1) ? 1'b0 : 1'b1, 1, tag);
            if (i == n - 1) step(1, 0, 1, 0, 0, 1, "R4 sleep after last frame");
            else            step(1, 0, 1, 1, 1, 1, tag);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 1, 1, 0, "R1 reset state");
        burst_len = 4'd2;
        step(1, 0, 0, 1, 1, 1, "R2 enter capture");
        step(1, 0, 1, 1, 1, 1, "R6 stray frame end ignored");
        step(1, 1, 0, 1, 1, 1, "R3 first start");
        step(1, 0, 1, 1, 1, 1, "R3 first end");
        step(1, 1, 0, 1, 0, 1, "R3 permit drops after last start");
        step(1, 1, 0, 1, 0, 1, "R9 extra start ignored");
        step(1, 0, 0, 1, 0, 1, "R9 still capturing");
        step(1, 0, 1, 0, 0, 1, "R4 sleep after last frame");
        // 19 further sleep cycles, with strobes sprinkled in
        for (int k = 1; k < 20; k++)
            step(1, (k % 3) == 0, (k % 4) == 1, 0, 0, 1, "R10 sleep holds under strobes");
        step(1, 0, 0, 1, 1, 1, "R5 wake after SLEEP_CYCLES");
        burst(2, "R5 fresh count after wake");
        step(1, 0, 0, 0, 0, 1, "R10 sleeping");
        step(0, 0, 0, 1, 1, 0, "R8 clear from sleep");
        burst_len = 4'd0;
        step(1, 0, 0, 1, 1, 1, "R2 enter capture again");
        burst(1, "R7 zero length acts as one");
        step(0, 0, 0, 1, 1, 0, "R8 clear after zero-length burst");
        burst_len = 4'd3;
        step(1, 0, 0, 1, 1, 1, "R2 enter capture third");
        step(1, 1, 0, 1, 1, 1, "R3 start in long burst");
        step(0, 0, 0, 1, 1, 0, "R8 clear from capture mid frame");
        step(0, 0, 1, 1, 1, 0, "R8 stays normal");
        step(1, 0, 0, 1, 1, 1, "R2 re-enter");
        step(1, 0, 1, 1, 1, 1, "R6 leftover frame end ignored");
        burst(3, "R3 three frame burst");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule